// File: doc/BRIEF.md
# Cascaded Bitwise Magnitude Comparator

This block compares two unsigned operands of a configurable width and reports whether the first is greater than, equal to or less than the second. It is built as a chain of identical one-bit cells. The chain starts at the most significant bit and ends at the least significant bit. Each cell takes a three-wire status (greater, equal, less) from its more significant neighbour and hands an updated status to the next cell. The status that leaves the least significant cell is the block's result.

A cell looks at its own pair of operand bits only while the incoming status says "equal so far". Once a more significant cell has found a difference, every later cell passes that verdict along unchanged. The status at the head of the chain comes from three seed inputs. Seeding with "equal" gives a plain comparison. Seeding with a fixed verdict lets a wider comparison be split across several of these blocks, each one fed by the block above it.

The block is purely combinational, and no clock passes through it. The result therefore settles after a ripple delay that grows in a straight line with the operand width.

Top module: `mag_cascade_cmp`

## Requirements
- R1: With the seed set to equal (gt=0, eq=1, lt=0), `gt_o` is 1 exactly when `opa_i` is greater than `opb_i` as unsigned numbers.
- R2: With the seed set to equal, `lt_o` is 1 exactly when `opa_i` is less than `opb_i` as unsigned numbers.
- R3: With the seed set to equal, `eq_o` is 1 exactly when the two operands are bit-for-bit identical.
- R4: With the seed set to greater (gt=1, eq=0, lt=0), the outputs are gt=1, eq=0, lt=0 whatever the operands.
- R5: With the seed set to less (gt=0, eq=0, lt=1), the outputs are gt=0, eq=0, lt=1 whatever the operands.
- R6: For any seed with exactly one of its three bits set, exactly one of the three outputs is 1.
- R7: With all three seed bits at 0, all three outputs are 0 whatever the operands.
- R8: The most significant differing bit decides the result, and the less significant bits have no effect on it. For example, 1011 against 1001 gives greater, and 1000 against 0111 gives greater.
- R9: The width parameter `WIDTH` sets the operand width, and R1 to R8 hold at widths other than the default of 4.
- R10: The outputs depend only on the present inputs. A change at the inputs shows up at the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First unsigned operand |
| opb_i | input | WIDTH | Second unsigned operand |
| seed_gt_i | input | 1 | Head-of-chain status: greater already decided |
| seed_eq_i | input | 1 | Head-of-chain status: equal so far |
| seed_lt_i | input | 1 | Head-of-chain status: less already decided |
| gt_o | output | 1 | Result: first operand is greater |
| eq_o | output | 1 | Result: operands are equal |
| lt_o | output | 1 | Result: first operand is less |

## Verification
A cell that holds the wrong status shows up at the outputs in the same evaluation, because there is no state to hide it. Some faults involve the equal link. If a cell drops it, the lower bits never get to decide, so pairs that differ only below that cell come out with every output low. If a cell forgets a verdict it has received, operands that differ above that cell but match below it come out as equal. Every operand pair is swept at two widths under all four seed patterns, so a fault at any bit position turns up on its first affected vector.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  // Status passed from one bit cell to the next (more significant to less).
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmp_status_t;

  localparam cmp_status_t ST_EQUAL = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/cmp_bit_stage.sv
module cmp_bit_stage
  import cmp_pkg::*;
(
  input  logic        a_bit,
  input  logic        b_bit,
  input  cmp_status_t st_in,
  output cmp_status_t st_out
);

  logic open_cmp;

  // A cell decides only while the upstream status is a clean "equal so far".
  assign open_cmp = st_in.eq & ~st_in.gt & ~st_in.lt;

  always_comb begin
    st_out = st_in;
    if (open_cmp) begin
      st_out.gt = a_bit & ~b_bit;
      st_out.lt = ~a_bit & b_bit;
      st_out.eq = ~(a_bit ^ b_bit);
    end
  end

  // R6: a one-hot status entering a cell leaves it one-hot
  always_comb begin
    if (!$isunknown({st_in, a_bit, b_bit}) && $countones(st_in) == 1)
      a_r6_onehot_kept: assert ($countones(st_out) == 1);
  end

  // R8: a verdict already made upstream is never revised by lower bits
  always_comb begin
    if (!$isunknown({st_in, a_bit, b_bit}) && (st_in.gt ^ st_in.lt) && !st_in.eq)
      a_r8_verdict_held: assert (st_out == st_in);
  end

endmodule

// File: rtl/cmp_ripple_chain.sv
module cmp_ripple_chain
  import cmp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_vec,
  input  logic [WIDTH-1:0] b_vec,
  input  cmp_status_t      head,
  output cmp_status_t      tail
);

  localparam int LINKS = WIDTH + 1;

  // link[WIDTH] is the seed; link[0] leaves the least significant cell.
  cmp_status_t link [LINKS];

  assign link[WIDTH] = head;

  for (genvar i = WIDTH - 1; i >= 0; i--) begin : g_cell
    cmp_bit_stage u_cell (
      .a_bit  (a_vec[i]),
      .b_bit  (b_vec[i]),
      .st_in  (link[i+1]),
      .st_out (link[i])
    );
  end

  assign tail = link[0];

endmodule

// File: rtl/mag_cascade_cmp.sv
module mag_cascade_cmp
  import cmp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             seed_gt_i,
  input  logic             seed_eq_i,
  input  logic             seed_lt_i,
  output logic             gt_o,
  output logic             eq_o,
  output logic             lt_o
);

  cmp_status_t seed_st;
  cmp_status_t result_st;

  assign seed_st = '{gt: seed_gt_i, eq: seed_eq_i, lt: seed_lt_i};

  cmp_ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .a_vec (opa_i),
    .b_vec (opb_i),
    .head  (seed_st),
    .tail  (result_st)
  );

  assign gt_o = result_st.gt;
  assign eq_o = result_st.eq;
  assign lt_o = result_st.lt;

  // R1, R2, R3: an equal seed yields the arithmetic ordering of the operands
  always_comb begin
    if (!$isunknown({opa_i, opb_i, seed_gt_i, seed_eq_i, seed_lt_i})
        && seed_st == ST_EQUAL) begin
      a_r1_greater: assert (gt_o == (opa_i > opb_i));
      a_r2_less:    assert (lt_o == (opa_i < opb_i));
      a_r3_equal:   assert (eq_o == (opa_i == opb_i));
    end
  end

  // R7: a blank seed produces a blank result
  always_comb begin
    if (!$isunknown({opa_i, opb_i, seed_gt_i, seed_eq_i, seed_lt_i})
        && !seed_gt_i && !seed_eq_i && !seed_lt_i)
      a_r7_blank_seed: assert ({gt_o, eq_o, lt_o} == 3'b000);
  end

endmodule

// File: tb/mag_cascade_cmp_test.sv
module mag_cascade_cmp_test;

  localparam int W_MAIN = 4;
  localparam int W_ALT  = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [W_MAIN-1:0] a4, b4;
  logic [W_ALT-1:0]  a6, b6;
  logic [2:0] seed4, seed6;
  logic gt4, eq4, lt4, gt6, eq6, lt6;

  mag_cascade_cmp #(.WIDTH(W_MAIN)) uut (
    .opa_i(a4), .opb_i(b4),
    .seed_gt_i(seed4[2]), .seed_eq_i(seed4[1]), .seed_lt_i(seed4[0]),
    .gt_o(gt4), .eq_o(eq4), .lt_o(lt4)
  );

  mag_cascade_cmp #(.WIDTH(W_ALT)) uut_w6 (
    .opa_i(a6), .opb_i(b6),
    .seed_gt_i(seed6[2]), .seed_eq_i(seed6[1]), .seed_lt_i(seed6[0]),
    .gt_o(gt6), .eq_o(eq6), .lt_o(lt6)
  );

  // Behavioural reference: seed encoded {gt,eq,lt}; result {gt,eq,lt}
  function automatic logic [2:0] model(input logic [2:0] seed, input int a, input int b);
    if (seed == 3'b010) begin
      if (a > b)       return 3'b100;
      else if (a < b)  return 3'b001;
      else             return 3'b010;
    end
    return seed;
  endfunction

  function automatic string tag_of(input logic [2:0] seed, input logic [2:0] exp);
    case (seed)
      3'b100: return "R4";
      3'b001: return "R5";
      3'b000: return "R7";
      default: return exp[2] ? "R1" : (exp[0] ? "R2" : "R3");
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got gt/eq/lt=%b expected %b", req, act, exp);
    end
  endtask

  task automatic run4(input logic [2:0] s, input int a, input int b, input string extra);
    logic [2:0] e;
    @(posedge clk);
    seed4 = s; a4 = a[W_MAIN-1:0]; b4 = b[W_MAIN-1:0];
    @(negedge clk);
    e = model(s, a, b);
    check({tag_of(s, e), extra}, {gt4, eq4, lt4}, e);
    if (s != 3'b000) check("R6", {2'b00, ($countones({gt4, eq4, lt4}) == 1)}, 3'b001);
  endtask

  task automatic run6(input logic [2:0] s, input int a, input int b);
    logic [2:0] e;
    @(posedge clk);
    seed6 = s; a6 = a[W_ALT-1:0]; b6 = b[W_ALT-1:0];
    @(negedge clk);
    e = model(s, a, b);
    check({"R9/", tag_of(s, e)}, {gt6, eq6, lt6}, e);
  endtask

  initial begin
    logic [2:0] seeds [4];
    seeds[0] = 3'b010; seeds[1] = 3'b100; seeds[2] = 3'b001; seeds[3] = 3'b000;
    seed4 = 3'b010; a4 = '0; b4 = '0;
    seed6 = 3'b010; a6 = '0; b6 = '0;
    @(negedge clk);
    check("R3 initial", {gt4, eq4, lt4}, 3'b010);

    // R8: the most significant difference decides
    run4(3'b010, 4'b1011, 4'b1001, " R8");
    run4(3'b010, 4'b1000, 4'b0111, " R8");
    run4(3'b010, 4'b0111, 4'b1000, " R8");

    // R10: inputs change mid-cycle; the result follows with no edge
    @(negedge clk);
    seed4 = 3'b010; a4 = 4'd3; b4 = 4'd9;
    #2;
    check("R10", {gt4, eq4, lt4}, 3'b001);
    a4 = 4'd12;
    #2;
    check("R10", {gt4, eq4, lt4}, 3'b100);

    for (int s = 0; s < 4; s++)
      for (int a = 0; a < (1 << W_MAIN); a++)
        for (int b = 0; b < (1 << W_MAIN); b++)
          run4(seeds[s], a, b, "");

    for (int s = 0; s < 4; s++)
      for (int a = 0; a < (1 << W_ALT); a++)
        for (int b = 0; b < (1 << W_ALT); b++)
          run6(seeds[s], a, b);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule